// File: doc/BRIEF.md
# Polynomial-Gated Tone Channel

This block is one voice of a retro-style sound generator. A frequency value sets a down-counter that divides a stream of clock-enable ticks. Each underflow of that counter yields a candidate pulse. The pulse is then either passed or blocked by a mix of pseudo-random bits. Four shift-register generators (4, 5, 9 and 17 bits wide) produce those bits, and all four live inside the block. A pulse that passes toggles a divide-by-two flip-flop, and that flip-flop forms the square wave.

A control byte holds three fields: a 3-bit distortion code that chooses which generator bits take part in the gating, a volume-only flag, and a 4-bit volume. The output is a 4-bit amplitude. In tone mode the amplitude follows the flip-flop. In volume-only mode it is a constant level. A separate select input swaps the 17-bit generator for the 9-bit one.

Top module: `poly_tone_channel`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, the counter holds 0 and the toggle flip-flop holds 0. With ctrl_i[4] clear, amp_o therefore reads 0. Every generator resets to all ones.
- R2: On each cycle with tick_i high, the counter behaves as follows. If it holds 0, that is an underflow: it reloads from freq_i and offers a pulse. Otherwise it decrements by one. With the pure-tone codes, the flip-flop changes on every underflow and on nothing else. A cycle with tick_i low changes neither the counter nor the flip-flop.
- R3: A new freq_i value changes nothing in a period that is already running. It is first used at the next reload. The period is therefore freq_i+1 ticks.
- R4: The distortion code ctrl_i[7:5] selects the generator bits that take part in gating: 000 uses the 5-bit and long bits; 001 and 011 use the 5-bit bit; 010 uses the 5-bit and 4-bit bits; 100 uses the long bit; 101 and 111 use none, which gives a pure tone; 110 uses the 4-bit bit.
- R5: An underflow toggles the flip-flop only if every selected generator bit is 1 in that same cycle.
- R6: While ctrl_i[4] is 1, amp_o equals ctrl_i[3:0] in every cycle, whatever the flip-flop holds.
- R7: While ctrl_i[4] is 0, amp_o equals ctrl_i[3:0] when the flip-flop is 1 and 0 when it is 0.
- R8: Every generator advances on every clock cycle, ticks or not. Each is a right shift whose new top bit is state[0] XOR state[k], with k = 1, 2, 4 and 3 for the 4-, 5-, 9- and 17-bit widths. The output bit of each generator is state[0]. No generator ever reaches all zeros.
- R9: short_poly_i = 1 makes the long bit the 9-bit generator output. short_poly_i = 0 makes it the 17-bit generator output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable pulse that the counter divides |
| freq_i | input | 8 | Divider reload value |
| ctrl_i | input | 8 | Distortion code [7:5], volume-only flag [4], volume [3:0] |
| short_poly_i | input | 1 | Selects the 9-bit generator in place of the 17-bit one |
| amp_o | output | 4 | Output amplitude |

## Verification
The bench targets four corner cases, each with its own failure signature.

- freq_i = 0 with a tick on every cycle. This is the fastest case, with an underflow on every tick. A counter that reloads one step late would halve the rate.
- A freq_i change in the middle of a period. A design that loaded the new value at once would cut the period short instead of finishing it.
- Gating codes that select two generators. A design that ORed the bits instead of ANDing them would toggle too often.
- Swaps of short_poly_i. A wrong tap or a wrong sequence choice would show up as toggles that appear or go missing against the bench model.

Two further cases are covered. Cycles with no tick must leave the output frozen. Volume-only mode is switched on and off around a live tone, and must hide the flip-flop without disturbing it.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

   typedef struct packed {
      logic use4;
      logic use5;
      logic uselong;
   } poly_pick_t;

   function automatic poly_pick_t pick_polys(input logic [2:0] code);
      poly_pick_t p;
      p = '0;
      case (code)
         3'b000: begin p.use5 = 1'b1; p.uselong = 1'b1; end
         3'b001, 3'b011: p.use5 = 1'b1;
         3'b010: begin p.use5 = 1'b1; p.use4 = 1'b1; end
         3'b100: p.uselong = 1'b1;
         3'b110: p.use4 = 1'b1;
         default: p = '0;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/ptc_lfsr.sv
module ptc_lfsr #(
   parameter int W   = 4,
   parameter int TAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic bit_o
);
   generate
      if (W < 2 || TAP < 1 || TAP >= W) begin : g_bad
         $error("ptc_lfsr: illegal width or tap");
      end
   endgenerate

   logic [W-1:0] sr_q;
   logic         fb;

   assign fb    = sr_q[0] ^ sr_q[TAP];
   assign bit_o = sr_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '1;
      else        sr_q <= {fb, sr_q[W-1:1]};
   end
endmodule

// File: rtl/ptc_divider.sv
module ptc_divider #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic [W-1:0] load_i,
   output logic         uflow_o,
   output logic [W-1:0] cnt_o
);
   generate
      if (W < 1) begin : g_bad
         $error("ptc_divider: width must be positive");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   assign uflow_o = tick_i && (cnt_q == '0);
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (uflow_o) cnt_q <= load_i;
      else if (tick_i)  cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/ptc_shaper.sv
module ptc_shaper
   import ptc_pkg::*;
#(
   parameter int VOL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uflow_i,
   input  logic [2:0]       dist_i,
   input  logic             p4_i,
   input  logic             p5_i,
   input  logic             plong_i,
   input  logic             vol_only_i,
   input  logic [VOL_W-1:0] vol_i,
   output logic             tgl_o,
   output logic             pass_o,
   output logic [VOL_W-1:0] amp_o
);
   poly_pick_t pick;
   logic       tgl_q;

   assign pick   = pick_polys(dist_i);
   assign pass_o = uflow_i
                 & (~pick.use4    | p4_i)
                 & (~pick.use5    | p5_i)
                 & (~pick.uselong | plong_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tgl_q <= 1'b0;
      else if (pass_o) tgl_q <= ~tgl_q;
   end

   assign tgl_o = tgl_q;
   assign amp_o = (vol_only_i || tgl_q) ? vol_i : '0;
endmodule

// File: rtl/poly_tone_channel.sv
module poly_tone_channel #(
   parameter int FREQ_W = 8,
   parameter int VOL_W  = 4,
   localparam int CTRL_W = 3 + 1 + VOL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [FREQ_W-1:0] freq_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic              short_poly_i,
   output logic [VOL_W-1:0]  amp_o
);
   localparam int NPOLY = 4;
   localparam int PW [NPOLY] = '{4, 5, 9, 17};
   localparam int PT [NPOLY] = '{1, 2, 4, 3};

   logic [NPOLY-1:0]  pbit;
   logic              uflow;
   logic              pass;
   logic              tgl;
   logic [FREQ_W-1:0] cnt;
   logic              plong;

   generate
      if (VOL_W < 1) begin : g_bad
         $error("poly_tone_channel: volume width must be positive");
      end
      for (genvar i = 0; i < NPOLY; i++) begin : g_poly
         ptc_lfsr #(.W(PW[i]), .TAP(PT[i])) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .bit_o (pbit[i])
         );
      end
   endgenerate

   assign plong = short_poly_i ? pbit[2] : pbit[3];

   ptc_divider #(.W(FREQ_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .load_i  (freq_i),
      .uflow_o (uflow),
      .cnt_o   (cnt)
   );

   ptc_shaper #(.VOL_W(VOL_W)) u_shp (
      .clk        (clk),
      .rst_n      (rst_n),
      .uflow_i    (uflow),
      .dist_i     (ctrl_i[CTRL_W-1 -: 3]),
      .p4_i       (pbit[0]),
      .p5_i       (pbit[1]),
      .plong_i    (plong),
      .vol_only_i (ctrl_i[VOL_W]),
      .vol_i      (ctrl_i[VOL_W-1:0]),
      .tgl_o      (tgl),
      .pass_o     (pass),
      .amp_o      (amp_o)
   );
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
   parameter int FREQ_W = 8,
   parameter int VOL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic [FREQ_W-1:0] freq_i,
   input logic [VOL_W+3:0]  ctrl_i,
   input logic [VOL_W-1:0]  amp_o,
   input logic [FREQ_W-1:0] cnt,
   input logic              tgl,
   input logic              uflow
);
   // R1: state is clear in the first cycle after reset
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (cnt == '0 && !tgl));

   // R2: no tick leaves the counter and flip-flop untouched
   a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> ($stable(cnt) && $stable(tgl)));

   // R3: an underflow reloads the counter from freq_i
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      uflow |=> (cnt == $past(freq_i)));

   // R2: a pure-tone code toggles on every underflow
   a_r2_pure_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && ctrl_i[VOL_W+3 -: 3] inside {3'b101, 3'b111}) |=> (tgl != $past(tgl)));

   // R5: the flip-flop only changes after an underflow
   a_r5_toggle_needs_uflow: assert property (@(posedge clk) disable iff (!rst_n)
      (tgl != $past(tgl)) |-> $past(uflow));

   // R7: in tone mode a non-zero level is the volume
   a_r7_amp_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_i[VOL_W] && amp_o != '0) |-> (amp_o == ctrl_i[VOL_W-1:0] && tgl));
endmodule

bind poly_tone_channel ptc_checker #(.FREQ_W(FREQ_W), .VOL_W(VOL_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick_i (tick_i),
   .freq_i (freq_i),
   .ctrl_i (ctrl_i),
   .amp_o  (amp_o),
   .cnt    (cnt),
   .tgl    (tgl),
   .uflow  (uflow)
);

// File: tb/poly_tone_channel_test.sv
`timescale 1ns/1ps
module poly_tone_channel_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [7:0] freq_i = 8'd0;
   logic [7:0] ctrl_i = 8'd0;
   logic       short_poly_i = 1'b0;
   logic [3:0] amp_o;

   int checks = 0;
   int fails  = 0;
   string tag = "R7";

   logic [16:0] m4, m5, m9, m17;
   logic [7:0]  m_cnt;
   logic        m_tgl;

   always #2 clk = ~clk;

   poly_tone_channel uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freq_i(freq_i),
      .ctrl_i(ctrl_i), .short_poly_i(short_poly_i), .amp_o(amp_o)
   );

   function automatic logic [16:0] lfsr_next(input logic [16:0] s, input int w, input int k);
      logic fb;
      fb = s[0] ^ s[k];
      return (s >> 1) | ({16'd0, fb} << (w - 1));
   endfunction

   function automatic logic gate_ok(input logic [2:0] d, input logic b4, input logic b5, input logic bl);
      case (d)
         3'b000: return b5 & bl;
         3'b001, 3'b011: return b5;
         3'b010: return b5 & b4;
         3'b100: return bl;
         3'b110: return b4;
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [3:0] exp_amp(input logic [7:0] c, input logic t);
      return (c[4] || t) ? c[3:0] : 4'd0;
   endfunction

   task automatic check(input logic [3:0] act, input logic [3:0] exp, input string t);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: amp_o=%0d expected %0d at %0t", t, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m4 = 17'h0000f; m5 = 17'h0001f; m9 = 17'h001ff; m17 = 17'h1ffff;
      m_cnt = 8'd0; m_tgl = 1'b0;
   endtask

   task automatic cyc();
      logic bl;
      bl = short_poly_i ? m9[0] : m17[0];
      if (tick_i) begin
         if (m_cnt == 8'd0) begin
            m_cnt = freq_i;
            if (gate_ok(ctrl_i[7:5], m4[0], m5[0], bl)) m_tgl = ~m_tgl;
         end else m_cnt = m_cnt - 8'd1;
      end
      m4  = lfsr_next(m4, 4, 1);
      m5  = lfsr_next(m5, 5, 2);
      m9  = lfsr_next(m9, 9, 4);
      m17 = lfsr_next(m17, 17, 3);
      @(posedge clk);
      #1;
      check(amp_o, exp_amp(ctrl_i, m_tgl), tag);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
   end

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      model_reset();
      ctrl_i = 8'hAF;
      repeat (3) @(posedge clk);
      #1;
      check(amp_o, 4'd0, "R1");
      rst_n = 1'b1;
      tag = "R1"; cyc();

      // R2: fastest rate, pure tone, tick every cycle
      tag = "R2"; freq_i = 8'd0; tick_i = 1'b1;
      for (int i = 0; i < 8; i++) cyc();
      // R2: no ticks freeze the output
      tick_i = 1'b0;
      for (int i = 0; i < 6; i++) cyc();

      // R3: change freq mid period
      tag = "R3"; tick_i = 1'b1; freq_i = 8'd5;
      for (int i = 0; i < 3; i++) cyc();
      freq_i = 8'd1;
      for (int i = 0; i < 12; i++) cyc();

      // R6: volume only over a live tone
      tag = "R6"; ctrl_i = 8'hB9;
      for (int i = 0; i < 10; i++) cyc();
      tag = "R7"; ctrl_i = 8'hA9;
      for (int i = 0; i < 10; i++) cyc();

      // R4 R5 R8: every distortion code with a tick each cycle
      tick_i = 1'b1; freq_i = 8'd0;
      for (int d = 0; d < 8; d++) begin
         tag = "R5"; ctrl_i = {d[2:0], 5'h0C};
         for (int i = 0; i < 60; i++) cyc();
      end

      // R9: long-generator selection with code 100
      tag = "R9"; ctrl_i = 8'h8E;
      for (int s = 0; s < 4; s++) begin
         short_poly_i = s[0];
         for (int i = 0; i < 80; i++) cyc();
      end

      // R4 R8: constrained random mix
      tag = "R4";
      for (int i = 0; i < 20000; i++) begin
         tick_i = ($urandom % 3) != 0;
         if (($urandom % 64) == 0) freq_i = $urandom % 6;
         if (($urandom % 50) == 0) ctrl_i = $urandom;
         if (($urandom % 200) == 0) short_poly_i = $urandom;
         if (($urandom % 40) == 0) ctrl_i[4] = 1'b0;
         cyc();
      end

      tag = "R1";
      rst_n = 1'b0; model_reset(); ctrl_i = 8'hA7;
      @(posedge clk); #1;
      check(amp_o, 4'd0, "R1");
      summary();
   end
endmodule